// File: doc/BRIEF.md
# Shared Memory Port Arbiter (CPU versus DMA)

This block decides, every cycle, who drives a single memory port: the processor, or one of several DMA channels. Each DMA channel presents a request line and a 2-bit urgency code. The block picks one requesting channel and compares its urgency with the processor's request. It then raises exactly one grant in the same cycle. The grant logic is purely combinational. The only state is one bit that keeps the middle urgency level fair.

A low-urgency channel always yields to the processor. A high-urgency channel always takes the port. A normal-urgency channel alternates with the processor when both request: the processor wins the first contested attempt after reset, and the channel wins the next one. Requests and grants are plain level signals with no valid/ready stream. A requester that is not granted keeps its request high and tries again on a later cycle. The block stores nothing on its behalf.

Top module: `xfer_port_arbiter`

## Requirements
- R1: At most one of `cpu_gnt` and the bits of `dma_gnt` is high in any cycle.
- R2: A grant is only given to a side whose request is high in that cycle. When nothing requests, every grant is low, including during and right after reset.
- R3: Whenever at least one request is high, exactly one grant is high in the same cycle. With no DMA request, `cpu_req` alone yields `cpu_gnt`.
- R4: Urgency codes are read two bits per channel, channel n at `dma_lvl[2n+1:2n]`: 00 low, 01 normal, 10 high, 11 reserved. Code 11 ranks exactly like 10. Among requesting channels, the one with the highest rank is chosen. With no `cpu_req`, that channel is granted.
- R5: When requesting channels share the highest rank, the lowest channel number is chosen.
- R6: If `cpu_req` is high and the chosen channel has code 00, `cpu_gnt` is given.
- R7: If `cpu_req` is high and the chosen channel has code 10 or 11, the chosen channel is granted.
- R8: If `cpu_req` is high and the chosen channel has code 01, grants alternate over such contested attempts: the processor wins one, the channel wins the next. A channel never loses two such attempts in a row. Uncontested cycles and contests at other levels leave the turn unchanged.
- R9: Reset returns the turn so that the first normal-level contest after reset goes to the processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor wants the port this cycle |
| dma_req | input | NUM_CH | One request line per DMA channel |
| dma_lvl | input | 2*NUM_CH | Urgency code per channel, two bits each |
| cpu_gnt | output | 1 | Port granted to the processor |
| dma_gnt | output | NUM_CH | One-hot grant to one DMA channel |

## Verification
The bench aims at normal-level fairness. It runs long contested runs broken up by idle cycles and by high- and low-level contests. A design that flipped the turn on those cycles would let the channel win twice in a row or lose twice in a row. A reset in the middle of a run, taken while the turn favours the channel, exposes a turn bit that is not cleared: the first contest after reset would go to the channel. Codes 10 and 11 are set against each other on different channels. A design that ranked 11 above 10 would grant the higher-numbered channel instead of the lower one. Mixed codes with equal ranks check that ties resolve to the lowest index, not the highest.

// File: rtl/xarb_pkg.sv
`timescale 1ns/1ps
package xarb_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_NORM = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  // Rank used for comparison: reserved folds onto high.
  function automatic lvl_e rank_of(input logic [1:0] code);
    return (code == 2'b11) ? LVL_HIGH : lvl_e'(code);
  endfunction
endpackage

// File: rtl/xarb_dma_pick.sv
`timescale 1ns/1ps
module xarb_dma_pick
  import xarb_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0]   req,
  input  logic [2*NUM_CH-1:0] lvl,
  output logic                any,
  output logic [IDX_W-1:0]    idx,
  output lvl_e                top_lvl
);
  lvl_e rank [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_rank
    assign rank[g] = rank_of(lvl[2*g +: 2]);
  end

  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    any     = 1'b0;
    idx     = '0;
    top_lvl = LVL_LOW;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!any || rank[i] > top_lvl)) begin
        any     = 1'b1;
        idx     = IDX_W'(i);
        top_lvl = rank[i];
      end
    end
  end
endmodule

// File: rtl/xarb_turn.sv
`timescale 1ns/1ps
module xarb_turn (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_contest,
  input  logic dma_won,
  output logic dma_owed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dma_owed <= 1'b0;
    else if (norm_contest) dma_owed <= !dma_won;
  end
endmodule

// File: rtl/xfer_port_arbiter.sv
`timescale 1ns/1ps
module xfer_port_arbiter
  import xarb_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic [NUM_CH-1:0]   dma_req,
  input  logic [2*NUM_CH-1:0] dma_lvl,
  output logic                cpu_gnt,
  output logic [NUM_CH-1:0]   dma_gnt
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic             dma_any;
  logic [IDX_W-1:0] dma_idx;
  lvl_e             dma_top;
  logic             dma_owed;
  logic             dma_win;
  logic             norm_contest;

  xarb_dma_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .req     (dma_req),
    .lvl     (dma_lvl),
    .any     (dma_any),
    .idx     (dma_idx),
    .top_lvl (dma_top)
  );

  always_comb begin
    dma_win = 1'b0;
    if (dma_any) begin
      if (!cpu_req) dma_win = 1'b1;
      else begin
        unique case (dma_top)
          LVL_LOW:  dma_win = 1'b0;
          LVL_NORM: dma_win = dma_owed;
          default:  dma_win = 1'b1;
        endcase
      end
    end
  end

  assign norm_contest = cpu_req && dma_any && (dma_top == LVL_NORM);
  assign cpu_gnt      = cpu_req && !dma_win;

  xarb_turn u_turn (
    .clk          (clk),
    .rst_n        (rst_n),
    .norm_contest (norm_contest),
    .dma_won      (dma_win),
    .dma_owed     (dma_owed)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_gnt
    assign dma_gnt[g] = dma_win && (dma_idx == IDX_W'(g));
  end
endmodule

// File: rtl/xfer_port_arbiter_chk.sv
`timescale 1ns/1ps
module xfer_port_arbiter_chk #(
  parameter int NUM_CH = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_req,
  input logic [NUM_CH-1:0]   dma_req,
  input logic [2*NUM_CH-1:0] dma_lvl,
  input logic                cpu_gnt,
  input logic [NUM_CH-1:0]   dma_gnt
);
  logic       any_dma;
  logic [1:0] best;
  logic       norm_fight;
  logic       lost_last;

  always_comb begin
    any_dma = |dma_req;
    best    = 2'b00;
    for (int i = 0; i < NUM_CH; i++) begin
      if (dma_req[i]) begin
        if (dma_lvl[2*i +: 2] != 2'b00 && dma_lvl[2*i +: 2] != 2'b01) best = 2'b10;
        else if (dma_lvl[2*i +: 2] == 2'b01 && best == 2'b00) best = 2'b01;
      end
    end
    norm_fight = cpu_req && any_dma && best == 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lost_last <= 1'b0;
    else if (norm_fight) lost_last <= cpu_gnt;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt})); // R1
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_gnt & ~dma_req) == '0) && (!cpu_gnt || cpu_req)); // R2
  AST_NO_IDLE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req || any_dma) |-> ($countones({cpu_gnt, dma_gnt}) == 1)); // R3
  AST_LOW_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && any_dma && best == 2'b00) |-> cpu_gnt); // R6
  AST_HIGH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && best == 2'b10 && any_dma) |-> !cpu_gnt); // R7
  AST_NORM_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_fight && lost_last) |-> (dma_gnt != '0)); // R8
endmodule

bind xfer_port_arbiter xfer_port_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
  .dma_lvl(dma_lvl), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
);

// File: tb/xfer_port_arbiter_tb.sv
`timescale 1ns/1ps
module xfer_port_arbiter_tb;
  localparam int NCH = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cpu_req = 1'b0;
  logic [NCH-1:0] dma_req = '0;
  logic [2*NCH-1:0] dma_lvl = '0;
  logic           cpu_gnt;
  logic [NCH-1:0] dma_gnt;

  int checks = 0;
  int errors = 0;
  bit owed   = 0;   // model: channel is owed the next normal contest
  bit done   = 0;

  always #2.5 clk = ~clk;

  xfer_port_arbiter #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
    .dma_lvl(dma_lvl), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
  );

  function automatic int rank(input logic [1:0] c);
    return (c == 2'b11) ? 2 : int'(c);
  endfunction

  // Behavioural expectation for the current inputs; updates the model turn when commit is set.
  task automatic expect_now(output bit e_cpu, output logic [NCH-1:0] e_dma,
                            output string tag, input bit commit);
    int best = -1;
    int who  = -1;
    bit dwin;
    for (int i = 0; i < NCH; i++)
      if (dma_req[i] && rank(dma_lvl[2*i +: 2]) > best) begin
        best = rank(dma_lvl[2*i +: 2]);
        who  = i;
      end
    e_dma = '0;
    if (who < 0) begin
      dwin = 0;
      tag  = cpu_req ? "R3" : "R2";
    end else if (!cpu_req) begin
      dwin = 1;
      tag  = "R4";
    end else if (best == 0) begin
      dwin = 0;
      tag  = "R6";
    end else if (best == 2) begin
      dwin = 1;
      tag  = "R7";
    end else begin
      dwin = owed;
      tag  = "R8";
      if (commit) owed = !dwin;
    end
    e_cpu = cpu_req && !dwin;
    if (dwin) e_dma[who] = 1'b1;
  endtask

  task automatic check(input string tag, input logic got_c, input logic [NCH-1:0] got_d,
                       input logic exp_c, input logic [NCH-1:0] exp_d);
    checks++;
    if (got_c !== exp_c || got_d !== exp_d) begin
      errors++;
      $display("FAIL %s: cpu_gnt=%b dma_gnt=%b expected cpu_gnt=%b dma_gnt=%b",
               tag, got_c, got_d, exp_c, exp_d);
    end
  endtask

  // Drive at the falling edge, compare just before the rising edge.
  task automatic step(input logic c, input logic [NCH-1:0] r, input logic [2*NCH-1:0] p);
    bit e_c;
    logic [NCH-1:0] e_d;
    string tag;
    cpu_req = c; dma_req = r; dma_lvl = p;
    #2;
    expect_now(e_c, e_d, tag, 1'b1);
    check(tag, cpu_gnt, dma_gnt, e_c, e_d);
    checks++;
    if ($countones({cpu_gnt, dma_gnt}) > 1) begin
      errors++;
      $display("FAIL R1: grants=%b expected at most one high", {cpu_gnt, dma_gnt});
    end
    @(negedge clk);
  endtask

  function automatic logic [2*NCH-1:0] lv(input int ch, input logic [1:0] c);
    logic [2*NCH-1:0] v = '0;
    v[2*ch +: 2] = c;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cpu_req = 0; dma_req = '0; dma_lvl = '0;
    #1;
    // R2: nothing granted in reset with no requests
    check("R2", cpu_gnt, dma_gnt, 1'b0, '0);
    repeat (2) @(negedge clk);
    owed  = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(0, '0, '0);                                   // R2 idle
    step(1, '0, '0);                                   // R3 cpu alone
    step(0, 5'b00100, lv(2, 2'b00));                   // R4 single low channel alone
    step(0, 5'b10010, lv(4, 2'b10) | lv(1, 2'b01));    // R4 higher rank wins
    step(0, 5'b01010, lv(3, 2'b11) | lv(1, 2'b10));    // R4 reserved equals high -> ch1
    step(0, 5'b11000, lv(4, 2'b10) | lv(3, 2'b11));    // R5 tie -> ch3
    step(0, 5'b00110, lv(2, 2'b01) | lv(1, 2'b01));    // R5 tie -> ch1
    step(1, 5'b00011, '0);                             // R6 low yields
    step(1, 5'b00001, lv(0, 2'b11));                   // R7 reserved takes
    step(1, 5'b10000, lv(4, 2'b10));                   // R7 high takes
    // R8: alternation with interruptions that must not move the turn
    step(1, 5'b00010, lv(1, 2'b01));                   // cpu
    step(0, 5'b00010, lv(1, 2'b01));                   // uncontested
    step(1, 5'b00100, lv(2, 2'b10));                   // high contest
    step(1, 5'b00001, '0);                             // low contest
    step(1, 5'b00010, lv(1, 2'b01));                   // dma
    step(1, 5'b01000, lv(3, 2'b01));                   // cpu
    step(1, 5'b01001, lv(3, 2'b01) | lv(0, 2'b01));    // dma ch0
    step(1, 5'b00010, lv(1, 2'b01));                   // cpu -> owed now set
    // R9: reset clears the turn; first normal contest goes to cpu
    do_reset();
    step(1, 5'b00010, lv(1, 2'b01));
    step(1, 5'b00010, lv(1, 2'b01));
    for (int k = 0; k < 4000; k++) begin
      logic [2*NCH-1:0] p = (NCH*2)'($urandom);
      logic [NCH-1:0]   r = NCH'($urandom) & NCH'($urandom);
      step(($urandom % 3) != 0, r, p);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule